// File: doc/BRIEF.md
# Zero-page bit set/clear sequencer

This unit runs the single-bit set and clear instructions of an 8-bit processor against zero-page memory. It sits on a synchronous byte-wide memory port. Read data for an address appears on `mem_rdata` one cycle after the address is presented. A write takes effect at the clock edge that ends the cycle in which `mem_we` is high.

A pulse on `start` while the unit is idle begins one instruction. The unit captures the program counter and the status byte, then fetches the opcode and the one-byte operand. It reads the addressed zero-page byte, waits one cycle with no write, and writes the byte back with exactly one bit changed.

In the final cycle the unit raises `done` for one cycle. In that cycle it presents the advanced program counter, the untouched status byte and the elapsed cycle count. An opcode outside the handled group is reported with `illegal`. Such an opcode causes no write and leaves the program counter unchanged.

Top module: `zpbit_seq`

## Requirements
- R1: An opcode is handled when its bits 3:0 equal 4'h7. Bit 7 selects set (1) or clear (0), and bits 6:4 give the bit index 0..7, so 8'h87..8'hF7 set bits 0..7 and 8'h07..8'h77 clear bits 0..7.
- R2: A set operation writes back the read byte ORed with the one-hot mask (1 << index), with every other bit unchanged.
- R3: A clear operation writes back the read byte ANDed with the inverse of (1 << index), with every other bit unchanged.
- R4: The operand byte is the whole effective address. Data read and write use address {8'h00, operand}.
- R5: Every instruction takes exactly five cycles from acceptance. `done` is high only in the fifth cycle, for one cycle. `cycles` restarts at 1 in the first cycle of each instruction and reads 5 while `done` is high.
- R6: The cycles follow a fixed order. Cycle 1 addresses pc and cycle 2 addresses pc+1. Cycles 3 and 4 address the zero-page byte. `mem_we` is low in cycles 1 to 4 and is high only in cycle 5.
- R7: For a handled opcode, `pc_out` equals the captured pc plus 2 while `done` is high.
- R8: `status_out` equals the status byte captured at acceptance, bit for bit, while `done` is high.
- R9: For an unhandled opcode, `illegal` is high with `done`, `mem_we` stays low in all five cycles, the zero-page byte keeps its value, and `pc_out` equals the captured pc.
- R10: `start` is ignored while an instruction is in progress. The running instruction still completes in five cycles, and `done` does not repeat until a new request is accepted.
- R11: After reset, `done`, `mem_we`, `illegal` and `cycles` are 0, and `pc_out` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run one instruction, taken only when idle |
| pc_in | input | 16 | Program counter at the start of the instruction |
| status_in | input | 8 | Processor status byte to carry through |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Opcode not handled, valid with done |
| pc_out | output | 16 | Program counter after the instruction |
| status_out | output | 8 | Status byte after the instruction |
| cycles | output | 4 | Cycles elapsed in the current instruction |

## Verification
The hardest condition to reach from the ports is a start request that arrives while an instruction is still running. A restart would be invisible in the data, because it would re-fetch the same bytes. The bench therefore holds `start` high through cycles 1 to 4 and tracks the address, the write enable and the cycle count in every cycle. A restart would show up as a repeated opcode fetch or a count that falls back to 1. All 240 unhandled opcodes are also swept with operands that point at live data, which proves that the guarded write never reaches memory.

// File: rtl/zpbit_pkg.sv
package zpbit_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam logic [3:0] HANDLED_LOW = 4'h7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH_OP,
        PH_FETCH_ZP,
        PH_READ,
        PH_HOLD,
        PH_WRITE
    } phase_e;

    typedef struct packed {
        logic             legal;
        logic             set;
        logic [IDX_W-1:0] idx;
    } bitop_s;

    function automatic bitop_s decode_op(input logic [DATA_W-1:0] op);
        bitop_s d;
        d.legal = (op[3:0] == HANDLED_LOW);
        d.set   = op[7];
        d.idx   = op[6:4];
        return d;
    endfunction

endpackage

// File: rtl/zpbit_decode.sv
module zpbit_decode
    import zpbit_pkg::*;
(
    input  logic [DATA_W-1:0] opcode,
    output bitop_s            op
);
    assign op = decode_op(opcode);
endmodule

// File: rtl/zpbit_modify.sv
module zpbit_modify #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  idx,
    input  logic              set,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = (idx == IDX_W'(i)) ? set : din[i];
    end
endmodule

// File: rtl/zpbit_ctrl.sv
module zpbit_ctrl
    import zpbit_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output phase_e           phase,
    output logic             launch,
    output logic [CYC_W-1:0] cycles
);
    phase_e phase_n;

    assign launch = start && (phase == PH_IDLE);

    always_comb begin
        case (phase)
            PH_IDLE:     phase_n = launch ? PH_FETCH_OP : PH_IDLE;
            PH_FETCH_OP: phase_n = PH_FETCH_ZP;
            PH_FETCH_ZP: phase_n = PH_READ;
            PH_READ:     phase_n = PH_HOLD;
            PH_HOLD:     phase_n = PH_WRITE;
            default:     phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cycles <= '0;
        end else begin
            phase <= phase_n;
            if (launch)
                cycles <= CYC_W'(1);
            else if (phase != PH_IDLE && phase != PH_WRITE)
                cycles <= cycles + CYC_W'(1);
        end
    end
endmodule

// File: rtl/zpbit_seq.sv
module zpbit_seq
    import zpbit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] status_in,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              done,
    output logic              illegal,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] status_out,
    output logic [CYC_W-1:0]  cycles
);
    localparam int PAGE_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] INSN_LEN = ADDR_W'(2);

    phase_e            phase;
    logic              launch;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] st_q;
    logic [DATA_W-1:0] op_q;
    logic [DATA_W-1:0] zp_q;
    logic [DATA_W-1:0] dat_q;
    bitop_s            dec;
    logic [DATA_W-1:0] mod_byte;
    logic              in_write;

    zpbit_ctrl #(.CYC_W(CYC_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .phase  (phase),
        .launch (launch),
        .cycles (cycles)
    );

    zpbit_decode u_dec (
        .opcode (op_q),
        .op     (dec)
    );

    zpbit_modify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mod (
        .din  (dat_q),
        .idx  (dec.idx),
        .set  (dec.set),
        .dout (mod_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            st_q  <= '0;
            op_q  <= '0;
            zp_q  <= '0;
            dat_q <= '0;
        end else begin
            if (launch) begin
                pc_q <= pc_in;
                st_q <= status_in;
            end
            case (phase)
                PH_FETCH_ZP: op_q  <= mem_rdata;
                PH_READ:     zp_q  <= mem_rdata;
                PH_HOLD:     dat_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_FETCH_OP: mem_addr = pc_q;
            PH_FETCH_ZP: mem_addr = pc_q + ADDR_W'(1);
            PH_READ:     mem_addr = {{PAGE_W{1'b0}}, mem_rdata};
            PH_HOLD,
            PH_WRITE:    mem_addr = {{PAGE_W{1'b0}}, zp_q};
            default:     mem_addr = pc_q;
        endcase
    end

    assign in_write   = (phase == PH_WRITE);
    assign done       = in_write;
    assign mem_we     = in_write && dec.legal;
    assign illegal    = in_write && !dec.legal;
    assign mem_wdata  = mod_byte;
    assign pc_out     = pc_q + (dec.legal ? INSN_LEN : '0);
    assign status_out = st_q;
endmodule

// File: rtl/zpbit_seq_chk.sv
module zpbit_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] pc_in,
    input logic [DATA_W-1:0] status_in,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              done,
    input logic              illegal,
    input logic [ADDR_W-1:0] pc_out,
    input logic [DATA_W-1:0] status_out,
    input logic [CYC_W-1:0]  cycles
);
    AST_WE_ONLY_FINAL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> done); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_DONE_AT_FIVE: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles == CYC_W'(5))); // R5
    AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == '0)); // R4
    AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1)); // R2
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && !mem_we)); // R9
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (done && !illegal) |-> (pc_out == $past(pc_in, 5) + ADDR_W'(2))); // R7
    AST_STATUS_KEPT: assert property (@(posedge clk) disable iff (rst)
        done |-> (status_out == $past(status_in, 5))); // R8
endmodule

bind zpbit_seq zpbit_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(8), .CYC_W(CYC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_in      (pc_in),
    .status_in  (status_in),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .done       (done),
    .illegal    (illegal),
    .pc_out     (pc_out),
    .status_out (status_out),
    .cycles     (cycles)
);

// File: tb/zpbit_seq_bench.sv
`timescale 1ns/1ps
module zpbit_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        done;
    logic        illegal;
    logic [15:0] pc_out;
    logic [7:0]  status_out;
    logic [3:0]  cycles;

    logic [7:0] mem [0:1023];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    zpbit_seq u_zpbit_seq (
        .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .status_in(status_in),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .done(done), .illegal(illegal), .pc_out(pc_out),
        .status_out(status_out), .cycles(cycles)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic run_one(input logic [7:0] op, input logic [7:0] zp, input logic [7:0] data,
                           input logic [15:0] pc, input logic [7:0] st, input bit hold);
        bit legal = (op[3:0] == 4'h7);
        logic [7:0] mask = 8'(1 << op[6:4]);
        logic [7:0] exp_byte;
        logic [15:0] zaddr = {8'h00, zp};
        bit seq_ok = 1;
        int n;
        int we_seen = 0;
        exp_byte = !legal ? data : (op[7] ? (data | mask) : (data & ~mask));
        @(negedge clk);
        mem[pc[9:0]] = op;
        mem[pc[9:0] + 10'd1] = zp;
        mem[zp] = data;
        pc_in = pc;
        status_in = st;
        start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        n = 1;
        forever begin
            if (mem_we) we_seen++;
            case (n)
                1: seq_ok &= (mem_addr == pc) && !mem_we;
                2: seq_ok &= (mem_addr == pc + 16'd1) && !mem_we;
                3, 4: seq_ok &= (mem_addr == zaddr) && !mem_we;
                5: seq_ok &= (mem_addr == zaddr) && (mem_we == legal);
                default: seq_ok = 0;
            endcase
            if (done || n >= 12) break;
            @(negedge clk);
            n++;
            if (n == 5) start = 1'b0;
        end
        // R5 R10: done exactly in cycle 5, counter reads 5
        chk(n == 5 && done, hold ? "R10" : "R5", n, 5);
        chk(cycles == 4'd5, "R5", cycles, 5);
        // R6 cycle order and dummy cycle
        chk(seq_ok && we_seen == (legal ? 1 : 0), "R6", we_seen, legal ? 1 : 0);
        // R7 / R9 program counter
        chk(pc_out == (legal ? pc + 16'd2 : pc), legal ? "R7" : "R9", pc_out, legal ? pc + 16'd2 : pc);
        // R8 status pass-through
        chk(status_out == st, "R8", status_out, st);
        // R1 / R9 illegal flag
        chk(illegal == !legal, legal ? "R1" : "R9", illegal, !legal);
        @(negedge clk);
        // R2 / R3 / R4 / R9 memory contents after the write edge
        chk(mem[zp] == exp_byte, !legal ? "R9" : (op[7] ? "R2" : "R3"), mem[zp], exp_byte);
        chk(!done, "R10", done, 0);
    endtask

    initial begin
        #(200000 * 5);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!done && !mem_we && !illegal, "R11", {done, mem_we, illegal}, 0);
        chk(cycles == 4'd0 && pc_out == 16'h0000, "R11", pc_out, 0);

        // R1 R2 R3 R4: all handled opcodes against several data patterns
        for (int b = 0; b < 8; b++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [7:0] pat;
                    case (p)
                        0: pat = 8'h00;
                        1: pat = 8'hFF;
                        2: pat = 8'hA5;
                        default: pat = 8'h5A;
                    endcase
                    run_one({s[0], b[2:0], 4'h7}, 8'(b * 29 + s * 7 + p * 61 + 3), pat,
                            16'h0100 + 16'((b * 8 + s * 4 + p) * 8), 8'hCC ^ 8'(b * 17 + p), 1'b0);
                end
            end
        end

        // R9: every unhandled opcode
        for (int op = 0; op < 256; op++) begin
            if (op[3:0] != 4'h7)
                run_one(8'(op), 8'(op) ^ 8'h5A, 8'(op), 16'h0200 + 16'(op[5:0] * 8), 8'(op), 1'b0);
        end

        // R10: start held high while running
        run_one(8'hB7, 8'h43, 8'h00, 16'h0300, 8'hCC, 1'b1);
        run_one(8'h37, 8'h44, 8'hFF, 16'h0310, 8'h33, 1'b1);

        finish_run();
    end
endmodule